// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block is the timekeeping core of a real-time clock. It holds the time of day and the calendar as seven packed-BCD register bytes: seconds, minutes, hours, day of week, date of month, month and two-digit year. A base-rate enable pulse, typically from the oscillator divider, drives an internal divide-by-`SUBDIV` chain. Each time that chain completes, the time advances by one second, and the carries ripple through minutes, hours, the day-of-week count, the date, the month and the year in the same cycle.

A host-side interface uses a byte-wide write port to set any one of the seven registers in a cycle, and reads all seven bytes from parallel outputs. The hours byte works in either 24-hour or 12-hour format, and in 12-hour format it carries an AM/PM flag. The most significant bit of the seconds byte is a halt control that freezes timekeeping. The date wraps at the true end of each month, including February in leap years from 2000 to 2099.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the bytes read seconds 00h, minutes 00h, hours 00h (24-hour format), day 01h, date 01h, month 01h and year 00h, and the halt bit is 0.
- R2: Seconds and minutes count 00 to 59 in BCD. Seconds advance once for every `SUBDIV` base enables and carry into minutes at 59; minutes carry into hours at 59.
- R3: While seconds bit 7 is 1, no time or calendar byte changes except through a write, and bit 7 reads back as written. Writing it to 0 resumes counting.
- R4: With hours bit 6 at 0 (24-hour format), bits 5:0 count BCD 00 to 23, and 23 wraps to 00 with a day carry.
- R5: With hours bit 6 at 1 (12-hour format), bits 4:0 hold the BCD hour 1 to 12 and bit 5 is 1 for PM. The sequence is 11→12 with bit 5 toggled, then 12→1 with bit 5 unchanged. The day carry happens only when 11 PM becomes 12 AM.
- R6: The date wraps to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February.
- R7: February ends after day 29 when the BCD year is a multiple of four (00 counts as a leap year), and after day 28 otherwise.
- R8: The day-of-week byte advances by one at each day carry, and 7 wraps to 1.
- R9: The month wraps from 12 to 01 with a year carry, and the year counts BCD 00 to 99 and wraps to 00.
- R10: A write to the seconds byte (address 0) restarts the sub-second divider. The next seconds increment follows exactly `SUBDIV` further base enables.
- R11: A write in the same cycle as a completed second stores the written value. No byte advances in that cycle.
- R12: Register addresses are 0 seconds, 1 hours' predecessor minutes, 2 hours, 3 day, 4 date, 5 month, 6 year. Bits outside each field are dropped on write and read as 0. The field masks are seconds 7Fh plus the halt bit, minutes 7Fh, hours 7Fh, day 07h, date 3Fh, month 1Fh and year FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_en | input | 1 | Sub-second base-rate enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Write data byte |
| seconds_o | output | 8 | Halt bit and BCD seconds |
| minutes_o | output | 8 | BCD minutes |
| hours_o | output | 8 | Format bit, PM or tens bit, BCD hour |
| day_o | output | 8 | Day of week 1 to 7 |
| date_o | output | 8 | BCD date of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |

## Verification
The bench goes after every wrap point. It covers the BCD 09→10 digit carry, 59→00, 23→00, and the four 12-hour transitions around noon and midnight, where a wrong design would toggle the PM flag at 12→1 or roll the date at noon. It writes 28 February in leap and non-leap years, including year 00. A leap test based on a binary year value rather than BCD digits would add or skip 29 February in those years. Writes land on the exact cycle of a completed second, and seconds writes land part-way through the divider. A design without write priority would lose the written value, and one without the divider restart would step seconds early. Random legal writes mixed with irregular base enables compare every byte against an integer model on every cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef enum logic [2:0] {
      REG_SEC  = 3'd0,
      REG_MIN  = 3'd1,
      REG_HOUR = 3'd2,
      REG_DAY  = 3'd3,
      REG_DATE = 3'd4,
      REG_MON  = 3'd5,
      REG_YEAR = 3'd6
   } rtc_reg_e;

   // two-digit BCD increment, caller handles the wrap
   function automatic logic [7:0] bcd_next(input logic [7:0] v);
      if (v[3:0] == 4'd9) bcd_next = {v[7:4] + 4'd1, 4'd0};
      else                bcd_next = {v[7:4], v[3:0] + 4'd1};
   endfunction

   // divisible by four straight from the digits: odd tens need 2 or 6
   function automatic logic year_is_leap(input logic [7:0] y);
      if (y[4]) year_is_leap = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      year_is_leap = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction

   function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      month_last = year_is_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
         default:                    month_last = 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
   parameter int SUBDIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic base_en,
   input  logic clear,
   output logic sec_pulse
);

   generate
      if (SUBDIV < 1) begin : g_bad_div
         $error("rtc_tick_div: SUBDIV must be at least 1");
      end

      if (SUBDIV == 1) begin : g_direct
         assign sec_pulse = base_en;
      end else begin : g_count
         localparam int CW = $clog2(SUBDIV);
         localparam logic [CW-1:0] LAST = CW'(SUBDIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cnt <= '0;
            else if (clear)     cnt <= '0;
            else if (base_en)   cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
         end

         assign sec_pulse = base_en && (cnt == LAST);

         // R10: a seconds write or halt leaves the divider at its start
         assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
            clear |=> cnt == '0);
      end
   endgenerate

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_pkg::*;
#(
   parameter logic [7:0] LOW  = 8'h00,
   parameter logic [7:0] MASK = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] load_val,
   input  logic       inc,
   input  logic [7:0] lim,
   output logic [7:0] q,
   output logic       carry
);

   logic       at_lim;
   logic [7:0] q_step;

   assign at_lim = (q == lim);
   assign q_step = at_lim ? LOW : bcd_next(q);
   assign carry  = inc && at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= LOW;
      else if (load)   q <= load_val & MASK;
      else if (inc)    q <= q_step;
   end

   // R2 (also R6, R8, R9 through the instances): wrap lands on the low bound
   assert_wrap_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !load && at_lim |=> q == LOW);

   // R12: bits outside the field never appear
   assert_field_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (q & ~MASK) == 8'h00);

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field #(
   parameter bit HAS_12H = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [6:0] load_val,
   input  logic       inc,
   output logic [6:0] q,
   output logic       day_carry
);

   localparam logic [6:0] LD_MASK = HAS_12H ? 7'h7F : 7'h3F;

   logic [6:0] nxt24, nxt12;
   logic       day24, day12;

   always_comb begin
      day24 = 1'b0;
      if (q[5:0] == 6'h23) begin
         nxt24 = 7'h00;
         day24 = 1'b1;
      end else if (q[3:0] == 4'h9) begin
         nxt24 = {1'b0, q[5:4] + 2'd1, 4'h0};
      end else begin
         nxt24 = {1'b0, q[5:4], q[3:0] + 4'd1};
      end
   end

   generate
      if (HAS_12H) begin : g_dual
         always_comb begin
            day12 = 1'b0;
            if (q[4:0] == 5'h11) begin
               nxt12 = {1'b1, ~q[5], 5'h12};
               day12 = q[5];
            end else if (q[4:0] == 5'h12) begin
               nxt12 = {1'b1, q[5], 5'h01};
            end else if (q[3:0] == 4'h9) begin
               nxt12 = {1'b1, q[5], 1'b1, 4'h0};
            end else begin
               nxt12 = {1'b1, q[5], q[4], q[3:0] + 4'd1};
            end
         end

         // R5: 11 AM becomes 12 PM
         assert_noon_pm_R5: assert property (@(posedge clk) disable iff (!rst_n)
            inc && !load && q == 7'h51 |=> q == 7'h72);
         // R5: 12 PM becomes 1 PM with no day carry
         assert_pm_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
            inc && !load && q == 7'h72 |-> !day_carry);
      end else begin : g_24only
         assign nxt12 = nxt24;
         assign day12 = day24;
      end
   endgenerate

   assign day_carry = inc && (q[6] ? day12 : day24);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 7'h00;
      else if (load)   q <= load_val & LD_MASK;
      else if (inc)    q <= q[6] ? nxt12 : nxt24;
   end

   // R4: 23 wraps to 00 in 24-hour format
   assert_midnight24_R4: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !load && q == 7'h23 |=> q == 7'h00);

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import rtc_pkg::*;
#(
   parameter int SUBDIV  = 32768,
   parameter bit HAS_12H = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       base_en,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic [7:0] seconds_o,
   output logic [7:0] minutes_o,
   output logic [7:0] hours_o,
   output logic [7:0] day_o,
   output logic [7:0] date_o,
   output logic [7:0] month_o,
   output logic [7:0] year_o
);

   logic       halt_q;
   logic       sec_pulse, advance;
   logic       wr_sec, wr_min, wr_hour, wr_day, wr_date, wr_mon, wr_year;
   logic       c_sec, c_min, c_day, c_dow, c_date, c_mon, c_year;
   logic [7:0] sec_q, min_q, day_q, date_q, mon_q, year_q, date_lim;
   logic [6:0] hour_q;

   assign wr_sec  = wr_en && (wr_addr == REG_SEC);
   assign wr_min  = wr_en && (wr_addr == REG_MIN);
   assign wr_hour = wr_en && (wr_addr == REG_HOUR);
   assign wr_day  = wr_en && (wr_addr == REG_DAY);
   assign wr_date = wr_en && (wr_addr == REG_DATE);
   assign wr_mon  = wr_en && (wr_addr == REG_MON);
   assign wr_year = wr_en && (wr_addr == REG_YEAR);

   rtc_tick_div #(.SUBDIV(SUBDIV)) u_div (
      .clk(clk), .rst_n(rst_n), .base_en(base_en),
      .clear(wr_sec || halt_q), .sec_pulse(sec_pulse)
   );

   // any write takes the whole cycle; a completed second is dropped
   assign advance = sec_pulse && !halt_q && !wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       halt_q <= 1'b0;
      else if (wr_sec)  halt_q <= wr_data[7];
   end

   rtc_bcd_field #(.LOW(8'h00), .MASK(8'h7F)) u_sec (
      .clk(clk), .rst_n(rst_n), .load(wr_sec), .load_val(wr_data),
      .inc(advance), .lim(8'h59), .q(sec_q), .carry(c_sec));

   rtc_bcd_field #(.LOW(8'h00), .MASK(8'h7F)) u_min (
      .clk(clk), .rst_n(rst_n), .load(wr_min), .load_val(wr_data),
      .inc(c_sec), .lim(8'h59), .q(min_q), .carry(c_min));

   rtc_hour_field #(.HAS_12H(HAS_12H)) u_hour (
      .clk(clk), .rst_n(rst_n), .load(wr_hour), .load_val(wr_data[6:0]),
      .inc(c_min), .q(hour_q), .day_carry(c_day));

   rtc_bcd_field #(.LOW(8'h01), .MASK(8'h07)) u_dow (
      .clk(clk), .rst_n(rst_n), .load(wr_day), .load_val(wr_data),
      .inc(c_day), .lim(8'h07), .q(day_q), .carry(c_dow));

   assign date_lim = month_last(mon_q, year_q);

   rtc_bcd_field #(.LOW(8'h01), .MASK(8'h3F)) u_date (
      .clk(clk), .rst_n(rst_n), .load(wr_date), .load_val(wr_data),
      .inc(c_day), .lim(date_lim), .q(date_q), .carry(c_date));

   rtc_bcd_field #(.LOW(8'h01), .MASK(8'h1F)) u_mon (
      .clk(clk), .rst_n(rst_n), .load(wr_mon), .load_val(wr_data),
      .inc(c_date), .lim(8'h12), .q(mon_q), .carry(c_mon));

   rtc_bcd_field #(.LOW(8'h00), .MASK(8'hFF)) u_year (
      .clk(clk), .rst_n(rst_n), .load(wr_year), .load_val(wr_data),
      .inc(c_mon), .lim(8'h99), .q(year_q), .carry(c_year));

   assign seconds_o = sec_q | {halt_q, 7'b0};
   assign minutes_o = min_q;
   assign hours_o   = {1'b0, hour_q};
   assign day_o     = day_q;
   assign date_o    = date_q;
   assign month_o   = mon_q;
   assign year_o    = year_q;

   // R3: a halted clock holds every byte unless written
   assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      halt_q && !wr_en |=> $stable({seconds_o, minutes_o, hours_o, day_o, date_o, month_o, year_o}));

   // R11: a minutes write is what appears, whatever the divider did
   assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_min |=> minutes_o == {1'b0, $past(wr_data[6:0])});

   // R12: upper day bits are dropped
   assert_day_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_day |=> day_o == {5'b0, $past(wr_data[2:0])});

   // R6: end of month lands on the first
   assert_month_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      c_date |=> date_o == 8'h01);

   // R9: year 99 wraps to 00 at the end of December
   assert_year_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      c_mon && year_q == 8'h99 |=> year_o == 8'h00 && !c_year);

endmodule

// File: tb/bcd_rtc_core_test.sv
`timescale 1ns/1ps
module bcd_rtc_core_test;

   localparam int SUBDIV = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       base_en, wr_en;
   logic [2:0] wr_addr;
   logic [7:0] wr_data;
   logic [7:0] seconds_o, minutes_o, hours_o, day_o, date_o, month_o, year_o;

   always #2.5 clk = ~clk;

   bcd_rtc_core #(.SUBDIV(SUBDIV), .HAS_12H(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .base_en(base_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data),
      .seconds_o(seconds_o), .minutes_o(minutes_o), .hours_o(hours_o),
      .day_o(day_o), .date_o(date_o), .month_o(month_o), .year_o(year_o));

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   string cur_req = "R1";

   // integer reference state
   int m_cnt, m_sec, m_min, m_h, m_dow, m_date, m_mon, m_yr;
   bit m_halt, m_12, m_pm;

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) + (v % 10));
   endfunction

   function automatic int unbcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int days_in(input int m, input int y);
      if (m == 2) return (y % 4 == 0) ? 29 : 28;
      if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] exp_hour();
      if (m_12) return 8'h40 | (m_pm ? 8'h20 : 8'h00) | bcd(m_h);
      return bcd(m_h);
   endfunction

   task automatic check_byte(input string req, input string what,
                             input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      check_byte(cur_req, "seconds", seconds_o, {m_halt, bcd(m_sec)[6:0]});
      check_byte(cur_req, "minutes", minutes_o, bcd(m_min));
      check_byte(cur_req, "hours",   hours_o,   exp_hour());
      check_byte(cur_req, "day",     day_o,     8'(m_dow));
      check_byte(cur_req, "date",    date_o,    bcd(m_date));
      check_byte(cur_req, "month",   month_o,   bcd(m_mon));
      check_byte(cur_req, "year",    year_o,    bcd(m_yr));
   endtask

   task automatic model_write(input logic [2:0] a, input logic [7:0] d);
      case (a)
         3'd0: begin m_halt = d[7]; m_sec = unbcd({1'b0, d[6:0]}); end
         3'd1: m_min = unbcd({1'b0, d[6:0]});
         3'd2: begin
            m_12 = d[6];
            if (m_12) begin m_pm = d[5]; m_h = unbcd({3'b0, d[4:0]}); end
            else      begin m_pm = 1'b0; m_h = unbcd({2'b0, d[5:0]}); end
         end
         3'd3: m_dow  = int'(d[2:0]);
         3'd4: m_date = unbcd({2'b0, d[5:0]});
         3'd5: m_mon  = unbcd({3'b0, d[4:0]});
         3'd6: m_yr   = unbcd(d);
         default: ;
      endcase
   endtask

   task automatic model_advance();
      bit day = 0;
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0;
         m_min++;
         if (m_min == 60) begin
            m_min = 0;
            if (m_12) begin
               if (m_h == 11)      begin m_h = 12; day = m_pm; m_pm = !m_pm; end
               else if (m_h == 12) m_h = 1;
               else                m_h++;
            end else begin
               m_h++;
               if (m_h == 24) begin m_h = 0; day = 1; end
            end
         end
      end
      if (day) begin
         m_dow = (m_dow == 7) ? 1 : m_dow + 1;
         m_date++;
         if (m_date > days_in(m_mon, m_yr)) begin
            m_date = 1;
            m_mon++;
            if (m_mon > 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
         end
      end
   endtask

   // one clock: drive at the falling edge, predict, compare at the next falling edge
   task automatic cycle(input bit be, input bit we, input logic [2:0] wa, input logic [7:0] wd);
      bit tk, adv;
      base_en = be; wr_en = we; wr_addr = wa; wr_data = wd;
      tk  = be && (m_cnt == SUBDIV - 1);
      adv = tk && !m_halt && !we;
      if ((we && wa == 3'd0) || m_halt) m_cnt = 0;
      else if (be) m_cnt = (m_cnt == SUBDIV - 1) ? 0 : m_cnt + 1;
      if (we) model_write(wa, wd);
      else if (adv) model_advance();
      @(posedge clk);
      @(negedge clk);
      base_en = 1'b0; wr_en = 1'b0;
      compare_all();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cycle(1'b1, 1'b0, 3'd0, 8'h00);
   endtask

   task automatic set_time(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] dt,
                           input logic [7:0] dw, input logic [7:0] hr, input logic [7:0] mi,
                           input logic [7:0] s);
      cycle(1'b0, 1'b1, 3'd6, y);
      cycle(1'b0, 1'b1, 3'd5, mo);
      cycle(1'b0, 1'b1, 3'd4, dt);
      cycle(1'b0, 1'b1, 3'd3, dw);
      cycle(1'b0, 1'b1, 3'd2, hr);
      cycle(1'b0, 1'b1, 3'd1, mi);
      cycle(1'b0, 1'b1, 3'd0, s);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] hold;
      int yrs[7] = '{0, 4, 12, 96, 1, 10, 98};
      void'($urandom(32'd7717));
      rst_n = 1'b0; base_en = 1'b0; wr_en = 1'b0; wr_addr = 3'd0; wr_data = 8'h00;
      m_cnt = 0; m_sec = 0; m_min = 0; m_h = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
      m_halt = 0; m_12 = 0; m_pm = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset image, fixed constants
      check_byte("R1", "seconds", seconds_o, 8'h00);
      check_byte("R1", "minutes", minutes_o, 8'h00);
      check_byte("R1", "hours",   hours_o,   8'h00);
      check_byte("R1", "day",     day_o,     8'h01);
      check_byte("R1", "date",    date_o,    8'h01);
      check_byte("R1", "month",   month_o,   8'h01);
      check_byte("R1", "year",    year_o,    8'h00);

      // R2 digit and minute carries
      cur_req = "R2";
      set_time(8'h21, 8'h06, 8'h14, 8'h03, 8'h09, 8'h59, 8'h58);
      run(2 * SUBDIV);
      check_byte("R2", "seconds", seconds_o, 8'h00);
      check_byte("R2", "minutes", minutes_o, 8'h00);
      check_byte("R2", "hours 09->10", hours_o, 8'h10);

      // R10 divider restart on a seconds write
      cur_req = "R10";
      run(2);
      cycle(1'b0, 1'b1, 3'd0, 8'h10);
      run(SUBDIV - 1);
      check_byte("R10", "seconds before full second", seconds_o, 8'h10);
      run(1);
      check_byte("R10", "seconds after full second", seconds_o, 8'h11);

      // R11 write on the cycle a second completes
      cur_req = "R11";
      run(SUBDIV - 1);
      hold = seconds_o;
      cycle(1'b1, 1'b1, 3'd1, 8'h33);
      check_byte("R11", "minutes written", minutes_o, 8'h33);
      check_byte("R11", "seconds not advanced", seconds_o, hold);

      // R3 halt freezes, clearing resumes
      cur_req = "R3";
      set_time(8'h21, 8'h06, 8'h14, 8'h03, 8'h05, 8'h20, 8'hB0);
      run(3 * SUBDIV);
      check_byte("R3", "halted seconds", seconds_o, 8'hB0);
      check_byte("R3", "halted minutes", minutes_o, 8'h20);
      cycle(1'b0, 1'b1, 3'd0, 8'h30);
      run(SUBDIV);
      check_byte("R3", "resumed seconds", seconds_o, 8'h31);

      // R4 and R8 24-hour midnight
      cur_req = "R4";
      set_time(8'h21, 8'h06, 8'h14, 8'h03, 8'h23, 8'h59, 8'h59);
      run(SUBDIV);
      check_byte("R4", "hours", hours_o, 8'h00);
      check_byte("R4", "date", date_o, 8'h15);
      check_byte("R8", "day", day_o, 8'h04);

      // R5 12-hour transitions
      cur_req = "R5";
      set_time(8'h21, 8'h06, 8'h14, 8'h03, 8'h51, 8'h59, 8'h59);
      run(SUBDIV);
      check_byte("R5", "11AM->12PM", hours_o, 8'h72);
      check_byte("R5", "no day at noon", date_o, 8'h14);
      set_time(8'h21, 8'h06, 8'h14, 8'h03, 8'h72, 8'h59, 8'h59);
      run(SUBDIV);
      check_byte("R5", "12PM->1PM", hours_o, 8'h61);
      set_time(8'h21, 8'h06, 8'h14, 8'h03, 8'h71, 8'h59, 8'h59);
      run(SUBDIV);
      check_byte("R5", "11PM->12AM", hours_o, 8'h52);
      check_byte("R5", "day carry at 12AM", date_o, 8'h15);
      set_time(8'h21, 8'h06, 8'h14, 8'h03, 8'h52, 8'h59, 8'h59);
      run(SUBDIV);
      check_byte("R5", "12AM->1AM", hours_o, 8'h41);

      // R6 month lengths
      cur_req = "R6";
      set_time(8'h21, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
      run(SUBDIV);
      check_byte("R6", "Apr 30 date", date_o, 8'h01);
      check_byte("R6", "Apr 30 month", month_o, 8'h05);
      set_time(8'h21, 8'h05, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
      run(SUBDIV);
      check_byte("R6", "May 30 date", date_o, 8'h31);
      set_time(8'h21, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
      run(SUBDIV);
      check_byte("R6", "Jan 31 month", month_o, 8'h02);

      // R7 February across leap and common years
      cur_req = "R7";
      foreach (yrs[k]) begin
         set_time(bcd(yrs[k]), 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
         run(SUBDIV);
         check_byte("R7", "Feb 28 next date", date_o, (yrs[k] % 4 == 0) ? 8'h29 : 8'h01);
         check_byte("R7", "Feb 28 next month", month_o, (yrs[k] % 4 == 0) ? 8'h02 : 8'h03);
         if (yrs[k] % 4 == 0) begin
            run(86400 * 0 + SUBDIV * 0);
            set_time(bcd(yrs[k]), 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
            run(SUBDIV);
            check_byte("R7", "Feb 29 next month", month_o, 8'h03);
         end
      end

      // R8 and R9 end of century
      cur_req = "R9";
      set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
      run(SUBDIV);
      check_byte("R9", "year", year_o, 8'h00);
      check_byte("R9", "month", month_o, 8'h01);
      check_byte("R9", "date", date_o, 8'h01);
      check_byte("R8", "day 7->1", day_o, 8'h01);

      // R12 out-of-field bits dropped
      cur_req = "R12";
      cycle(1'b0, 1'b1, 3'd1, 8'h92);
      check_byte("R12", "minutes", minutes_o, 8'h12);
      cycle(1'b0, 1'b1, 3'd3, 8'hFD);
      check_byte("R12", "day", day_o, 8'h05);
      cycle(1'b0, 1'b1, 3'd4, 8'hD5);
      check_byte("R12", "date", date_o, 8'h15);
      cycle(1'b0, 1'b1, 3'd5, 8'hE7);
      check_byte("R12", "month", month_o, 8'h07);
      cycle(1'b0, 1'b1, 3'd2, 8'h95);
      check_byte("R12", "hours", hours_o, 8'h15);

      // random legal writes mixed with irregular base enables, all requirements
      cur_req = "R2 random";
      for (int i = 0; i < 8000; i++) begin
         if ($urandom_range(0, 99) < 4) begin
            int a = $urandom_range(0, 6);
            bit near = $urandom_range(0, 1);
            int v;
            case (a)
               0: begin
                  v = near ? 59 - $urandom_range(0, 2) : $urandom_range(0, 59);
                  cycle($urandom_range(0, 1), 1'b1, 3'd0,
                        bcd(v) | (($urandom_range(0, 19) == 0) ? 8'h80 : 8'h00));
               end
               1: cycle($urandom_range(0, 1), 1'b1, 3'd1, bcd(near ? 59 : $urandom_range(0, 59)));
               2: begin
                  if ($urandom_range(0, 1)) begin
                     v = near ? 11 : $urandom_range(1, 12);
                     cycle($urandom_range(0, 1), 1'b1, 3'd2,
                           8'h40 | ($urandom_range(0, 1) ? 8'h20 : 8'h00) | bcd(v));
                  end else begin
                     cycle($urandom_range(0, 1), 1'b1, 3'd2, bcd(near ? 23 : $urandom_range(0, 23)));
                  end
               end
               3: cycle($urandom_range(0, 1), 1'b1, 3'd3, 8'($urandom_range(1, 7)));
               4: cycle($urandom_range(0, 1), 1'b1, 3'd4,
                        bcd(near ? days_in(m_mon, m_yr) : $urandom_range(1, 28)));
               5: begin
                  v = $urandom_range(1, 12);
                  if (m_date <= days_in(v, m_yr)) cycle(1'b1, 1'b1, 3'd5, bcd(v));
                  else cycle(1'b1, 1'b0, 3'd0, 8'h00);
               end
               default: begin
                  v = $urandom_range(0, 99);
                  if (!(m_mon == 2 && m_date == 29 && v % 4 != 0)) cycle(1'b1, 1'b1, 3'd6, bcd(v));
                  else cycle(1'b1, 1'b0, 3'd0, 8'h00);
               end
            endcase
         end else begin
            cycle($urandom_range(0, 3) != 0, 1'b0, 3'd0, 8'h00);
         end
      end

      finish_run();
   end

endmodule